// File: doc/BRIEF.md
# Block Register Transfer Sequencer

This block carries out one block-transfer instruction. It moves a chosen group of registers to consecutive memory words, or loads them from there. A pulse on `start_i` captures the 32-bit instruction word and the current value of the base register. The block decodes the word, works out the first address and the final base value, and then handles one register per memory beat. Each beat waits until memory accepts it. For a store, the register file is read through a combinational read port. For a load, the register file is written as each beat completes.

After the last beat the block can write the updated base value into the base register. A single-cycle `done_o` pulse closes the operation. If the encoding is illegal, `done_o` pulses with `illegal_o` set and nothing is touched.

The 16-bit register mask is held in two separate fields of the instruction word. One bank bit chooses whether the mask covers the lower or the upper half of a 32-entry register file.

Top module: `blkxfer_seq`

## Requirements
- R1: The word is legal only when bits [31:29] equal 3'b100 and bits [8:7] are both zero. A start with an illegal word makes `done_o` and `illegal_o` high for one cycle, one cycle after start. It performs no memory beat and no register write.
- R2: The mask is {instr[18:9], instr[5:0]}. The bank bit is instr[6]. Mask bit i names register i when the bank bit is 0, and register 16+i when it is 1.
- R3: Registers are handled in ascending register number, one memory beat each, and each beat's address is 4 above the previous one. The block makes exactly N beats, where N is the number of set mask bits.
- R4: The first address is set by U = instr[27] and P = instr[28]:
  - base when U=1, P=0
  - base+4 when U=1, P=1
  - base−4N+4 when U=0, P=0
  - base−4N when U=0, P=1
- R5: When L = instr[24] is 0 (store), each beat writes the current register's value to memory with `mem_we_o` high, and the register file is not written during beats.
- R6: When L is 1 (load), each beat writes `mem_rdata_i` into the current register in the cycle the beat is accepted, and `mem_we_o` stays low.
- R7: A beat holds its request, address and direction unchanged until `mem_ready_i` is high.
- R8: When W = instr[25] is 1, the base register, whose number is Rn = instr[23:19], is written after the last beat. The value is base+4N when U=1 and base−4N when U=0.
- R9: For a load whose mask includes Rn, the loaded value stays in Rn and the writeback is dropped.
- R10: An all-zero mask makes no memory beat. `done_o` rises one cycle after start when W is 0. When W is 1, it rises two cycles after start, with Rn rewritten to the unchanged base.
- R11: After reset, `busy_o`, `done_o` and `mem_req_o` are low. `done_o` is high for exactly one cycle per operation, and a start seen while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin an operation (taken only when idle) |
| instr_i | input | 32 | Block-transfer instruction word |
| base_i | input | ADDR_W | Current value of the base register |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| illegal_o | output | 1 | High with done_o when the encoding was illegal |
| mem_req_o | output | 1 | Memory beat request |
| mem_we_o | output | 1 | Beat direction, 1 = write to memory |
| mem_addr_o | output | ADDR_W | Byte address of the beat (word aligned steps) |
| mem_wdata_o | output | DATA_W | Store data |
| mem_rdata_i | input | DATA_W | Load data |
| mem_ready_i | input | 1 | Memory accepts the current beat |
| rf_raddr_o | output | 5 | Register-file read address |
| rf_rdata_i | input | DATA_W | Register-file read data (combinational) |
| rf_we_o | output | 1 | Register-file write enable |
| rf_waddr_o | output | 5 | Register-file write address |
| rf_wdata_o | output | DATA_W | Register-file write data |

## Verification
The bench builds the block with its default widths: 32-bit addresses and data, and the 16-bit mask fixed by the instruction layout. At these widths both register banks are reachable, and so is the full 16-register mask. The address ranges also fit a 64-word memory model, so every one of the four address modes can be compared word for word against a model, including transfers that read or write the base register itself. A ready signal that stalls on alternate cycles exercises the hold behaviour of each beat.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;

    // instruction field positions (decoded by this block)
    localparam int INSTR_W = 32;
    localparam int CLS_HI  = 31;
    localparam int CLS_LO  = 29;
    localparam logic [2:0] CLS_VAL = 3'b100;
    localparam int BIT_P   = 28;
    localparam int BIT_U   = 27;
    localparam int BIT_W   = 25;
    localparam int BIT_L   = 24;
    localparam int RN_HI   = 23;
    localparam int RN_LO   = 19;
    localparam int MHI_HI  = 18;
    localparam int MHI_LO  = 9;
    localparam int PAD_HI  = 8;
    localparam int PAD_LO  = 7;
    localparam int BIT_H   = 6;
    localparam int MLO_HI  = 5;
    localparam int MLO_LO  = 0;

    localparam int MASK_W  = (MHI_HI - MHI_LO + 1) + (MLO_HI - MLO_LO + 1);
    localparam int RF_AW   = RN_HI - RN_LO + 1;
    localparam int IDX_W   = $clog2(MASK_W);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_XFER  = 2'd1,
        ST_WBACK = 2'd2
    } seq_state_e;

endpackage

// File: rtl/blkxfer_lowbit.sv
module blkxfer_lowbit #(
    parameter  int WIDTH = 16,
    localparam int IW    = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] mask_i,
    output logic [IW-1:0]    idx_o,
    output logic             any_o
);

    logic [WIDTH:0]   seen;
    logic [WIDTH-1:0] first;

    assign seen[0] = 1'b0;

    generate
        for (genvar gi = 0; gi < WIDTH; gi++) begin : g_bit
            assign first[gi]    = mask_i[gi] & ~seen[gi];
            assign seen[gi + 1] = seen[gi] | mask_i[gi];
        end
    endgenerate

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < WIDTH; i++) begin
            if (first[i]) begin
                idx_o = IW'(i);
            end
        end
    end

    assign any_o = seen[WIDTH];

endmodule

// File: rtl/blkxfer_addr.sv
module blkxfer_addr #(
    parameter  int ADDR_W = 32,
    parameter  int MASK_W = 16,
    localparam int CNT_W  = $clog2(MASK_W + 1)
) (
    input  logic [MASK_W-1:0] mask_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic              up_i,
    input  logic              pre_i,
    output logic [ADDR_W-1:0] start_o,
    output logic [ADDR_W-1:0] final_o
);

    localparam logic [ADDR_W-1:0] WORD = ADDR_W'(4);

    logic [CNT_W-1:0]  cnt;
    logic [ADDR_W-1:0] span;

    always_comb begin
        cnt = '0;
        for (int i = 0; i < MASK_W; i++) begin
            cnt = cnt + CNT_W'(mask_i[i]);
        end
        span = ADDR_W'(cnt) << 2;
        if (up_i) begin
            start_o = pre_i ? (base_i + WORD) : base_i;
            final_o = base_i + span;
        end else begin
            start_o = pre_i ? (base_i - span) : (base_i - span + WORD);
            final_o = base_i - span;
        end
    end

endmodule

// File: rtl/blkxfer_seq.sv
module blkxfer_seq
    import blkxfer_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [INSTR_W-1:0] instr_i,
    input  logic [ADDR_W-1:0] base_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              illegal_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    input  logic              mem_ready_i,
    output logic [RF_AW-1:0]  rf_raddr_o,
    input  logic [DATA_W-1:0] rf_rdata_i,
    output logic              rf_we_o,
    output logic [RF_AW-1:0]  rf_waddr_o,
    output logic [DATA_W-1:0] rf_wdata_o
);

    typedef struct packed {
        seq_state_e        state;
        logic [MASK_W-1:0] mask;
        logic              bank;
        logic [RF_AW-1:0]  rn;
        logic              load;
        logic              wb_en;
        logic              wb_skip;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] wb_val;
        logic              done;
        logic              illegal;
    } seq_t;

    seq_t s_d, s_q;

    // ---------------- decode of the incoming word ----------------
    logic              cls_ok, pad_ok, legal;
    logic [MASK_W-1:0] mask_in;
    logic [RF_AW-1:0]  rn_in;
    logic              bank_in, base_hit;
    logic [ADDR_W-1:0] start_addr, final_base;

    assign cls_ok   = (instr_i[CLS_HI:CLS_LO] == CLS_VAL);
    assign pad_ok   = (instr_i[PAD_HI:PAD_LO] == '0);
    assign legal    = cls_ok & pad_ok;
    assign mask_in  = {instr_i[MHI_HI:MHI_LO], instr_i[MLO_HI:MLO_LO]};
    assign rn_in    = instr_i[RN_HI:RN_LO];
    assign bank_in  = instr_i[BIT_H];
    assign base_hit = (rn_in[RF_AW-1] == bank_in) && mask_in[rn_in[IDX_W-1:0]];

    blkxfer_addr #(
        .ADDR_W (ADDR_W),
        .MASK_W (MASK_W)
    ) addr_i (
        .mask_i  (mask_in),
        .base_i  (base_i),
        .up_i    (instr_i[BIT_U]),
        .pre_i   (instr_i[BIT_P]),
        .start_o (start_addr),
        .final_o (final_base)
    );

    // ---------------- current register of the walk ----------------
    logic [IDX_W-1:0]  cur_idx;
    logic              cur_any;
    logic [RF_AW-1:0]  cur_reg;
    logic [MASK_W-1:0] rem_mask;

    blkxfer_lowbit #(
        .WIDTH (MASK_W)
    ) pick_i (
        .mask_i (s_q.mask),
        .idx_o  (cur_idx),
        .any_o  (cur_any)
    );

    assign cur_reg  = {s_q.bank, cur_idx};
    assign rem_mask = s_q.mask & ~(MASK_W'(1) << cur_idx);

    // ---------------- next-state logic ----------------
    always_comb begin
        s_d         = s_q;
        s_d.done    = 1'b0;
        s_d.illegal = 1'b0;

        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = s_q.addr;
        mem_wdata_o = rf_rdata_i;
        rf_raddr_o  = cur_reg;
        rf_we_o     = 1'b0;
        rf_waddr_o  = cur_reg;
        rf_wdata_o  = mem_rdata_i;

        unique case (s_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    if (!legal) begin
                        s_d.done    = 1'b1;
                        s_d.illegal = 1'b1;
                    end else begin
                        s_d.mask    = mask_in;
                        s_d.bank    = bank_in;
                        s_d.rn      = rn_in;
                        s_d.load    = instr_i[BIT_L];
                        s_d.wb_en   = instr_i[BIT_W];
                        s_d.wb_skip = instr_i[BIT_L] & base_hit;
                        s_d.addr    = start_addr;
                        s_d.wb_val  = final_base;
                        if (mask_in != '0) begin
                            s_d.state = ST_XFER;
                        end else if (instr_i[BIT_W]) begin
                            s_d.state = ST_WBACK;
                        end else begin
                            s_d.done  = 1'b1;
                        end
                    end
                end
            end
            ST_XFER: begin
                mem_req_o = cur_any;
                mem_we_o  = ~s_q.load;
                if (s_q.load) begin
                    rf_we_o = mem_ready_i;
                end
                if (mem_ready_i) begin
                    s_d.mask = rem_mask;
                    s_d.addr = s_q.addr + ADDR_W'(4);
                    if (rem_mask == '0) begin
                        if (s_q.wb_en) begin
                            s_d.state = ST_WBACK;
                        end else begin
                            s_d.state = ST_IDLE;
                            s_d.done  = 1'b1;
                        end
                    end
                end
            end
            ST_WBACK: begin
                rf_we_o    = ~s_q.wb_skip;
                rf_waddr_o = s_q.rn;
                rf_wdata_o = DATA_W'(s_q.wb_val);
                s_d.state  = ST_IDLE;
                s_d.done   = 1'b1;
            end
            default: begin
                s_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o    = (s_q.state != ST_IDLE);
    assign done_o    = s_q.done;
    assign illegal_o = s_q.illegal;

    // ---------------- assertions ----------------
    AST_BEAT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)); // R7

    AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_req_o && mem_ready_i |=> !mem_req_o || (mem_addr_o == $past(mem_addr_o) + ADDR_W'(4))); // R3

    AST_REG_ASCEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_req_o && mem_ready_i |=> !mem_req_o || (rf_raddr_o > $past(rf_raddr_o))); // R3

    AST_STORE_NO_RFW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_req_o && mem_we_o |-> !rf_we_o); // R5

    AST_LOAD_ON_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_req_o && rf_we_o |-> mem_ready_i && !mem_we_o); // R6

    AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o); // R11

    AST_ILLEGAL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        illegal_o |-> done_o && !busy_o && $past(!busy_o)); // R1

    AST_REQ_IN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_req_o || rf_we_o) |-> busy_o); // R11

endmodule

// File: tb/blkxfer_seq_tb_top.sv
module blkxfer_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] base_in = '0;
    logic        busy, done, illegal;
    logic        mem_req, mem_we, mem_ready;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [4:0]  rf_raddr, rf_waddr;
    logic [31:0] rf_rdata, rf_wdata;
    logic        rf_we;

    always #2 clk = ~clk;   // 250 MHz

    logic [31:0] rf  [32];
    logic [31:0] mem [64];
    logic [31:0] exp_rf  [32];
    logic [31:0] exp_mem [64];

    logic phase = 1'b0;
    bit   stall_on = 1'b0;
    int   beat_cnt = 0;
    int   stall_cyc = 0;
    logic [31:0] first_addr = '0;

    int checks = 0;
    int fails  = 0;

    assign rf_rdata  = rf[rf_raddr];
    assign mem_rdata = mem[mem_addr[7:2]];
    assign mem_ready = mem_req & (!stall_on | phase);

    blkxfer_seq dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .start_i     (start),
        .instr_i     (instr),
        .base_i      (base_in),
        .busy_o      (busy),
        .done_o      (done),
        .illegal_o   (illegal),
        .mem_req_o   (mem_req),
        .mem_we_o    (mem_we),
        .mem_addr_o  (mem_addr),
        .mem_wdata_o (mem_wdata),
        .mem_rdata_i (mem_rdata),
        .mem_ready_i (mem_ready),
        .rf_raddr_o  (rf_raddr),
        .rf_rdata_i  (rf_rdata),
        .rf_we_o     (rf_we),
        .rf_waddr_o  (rf_waddr),
        .rf_wdata_o  (rf_wdata)
    );

    always @(posedge clk) begin
        phase <= ~phase;
        if (rf_we) rf[rf_waddr] <= rf_wdata;
        if (mem_req && mem_ready && mem_we) mem[mem_addr[7:2]] <= mem_wdata;
        if (mem_req && mem_ready) begin
            if (beat_cnt == 0) first_addr <= mem_addr;
            beat_cnt <= beat_cnt + 1;
        end
        if (mem_req && !mem_ready) stall_cyc <= stall_cyc + 1;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    function automatic logic [31:0] mk(input bit [2:0] cls, input bit p, input bit u, input bit w,
                                       input bit l, input bit [4:0] rn, input bit [1:0] pad,
                                       input bit h, input bit [15:0] m);
        return {cls, p, u, 1'b0, w, l, rn, m[15:6], pad, h, m[5:0]};
    endfunction

    task automatic init_state();
        for (int i = 0; i < 32; i++) begin
            rf[i] = 32'hA500_0000 + i;
            exp_rf[i] = rf[i];
        end
        for (int i = 0; i < 64; i++) begin
            mem[i] = 32'h5A00_0000 + (i << 8);
            exp_mem[i] = mem[i];
        end
    endtask

    // independent model of the requirements (R2, R4, R5, R6, R8, R9)
    task automatic model(input bit p, input bit u, input bit w, input bit l, input bit h,
                         input bit [4:0] rn, input bit [15:0] m, input logic [31:0] base,
                         output int n, output logic [31:0] st);
        logic [31:0] fin;
        logic [31:0] a;
        int k;
        n = 0;
        for (int i = 0; i < 16; i++) if (m[i]) n++;
        if (u) begin
            st = p ? base + 4 : base;
            fin = base + 4 * n;
        end else begin
            st = p ? base - 4 * n : base - 4 * n + 4;
            fin = base - 4 * n;
        end
        k = 0;
        for (int i = 0; i < 16; i++) begin
            if (m[i]) begin
                a = st + 4 * k;
                if (l) exp_rf[{h, 4'(i)}] = mem[a[7:2]];
                else   exp_mem[a[7:2]]    = rf[{h, 4'(i)}];
                k++;
            end
        end
        if (w && !(l && rn[4] == h && m[rn[3:0]])) exp_rf[rn] = fin;
    endtask

    task automatic compare(input string tag);
        int bad_r, bad_m;
        bad_r = 0;
        bad_m = 0;
        for (int i = 0; i < 32; i++) if (rf[i] !== exp_rf[i]) bad_r++;
        for (int i = 0; i < 64; i++) if (mem[i] !== exp_mem[i]) bad_m++;
        chk(bad_r == 0, {tag, " register file contents"}, bad_r, 0);
        chk(bad_m == 0, {tag, " memory contents"}, bad_m, 0);
    endtask

    bit got_done, got_ill;

    task automatic run_op(input logic [31:0] ins, input logic [31:0] base, input bit stall,
                          input bit intrude, output int lat);
        stall_on = stall;
        beat_cnt = 0;
        stall_cyc = 0;
        got_done = 0;
        got_ill = 0;
        @(negedge clk);
        start = 1'b1;
        instr = ins;
        base_in = base;
        lat = 0;
        while (lat < 500) begin
            @(negedge clk);
            lat++;
            if (lat == 1) start = 1'b0;
            if (intrude && lat == 2) begin
                start = 1'b1;
                instr = mk(3'b100, 1'b0, 1'b1, 1'b1, 1'b0, 5'd1, 2'b00, 1'b0, 16'h00FF);
                base_in = 32'h0;
            end
            if (intrude && lat == 3) start = 1'b0;
            if (done) begin
                got_done = 1;
                got_ill = illegal;
                break;
            end
        end
        chk(got_done, "R11 operation completes", lat, 0);
        @(negedge clk);
        chk(!done, "R11 done lasts one cycle", done, 0);
    endtask

    localparam int NVEC = 8;
    // {p, u, w, l, h, rn[4:0], mask[15:0], base[31:0]}
    localparam logic [57:0] VECS [NVEC] = '{
        {1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 5'd3,  16'h00F0, 32'h0000_0040},
        {1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 5'd2,  16'h8101, 32'h0000_0020},
        {1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 5'd20, 16'h0033, 32'h0000_00C0},
        {1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 5'd17, 16'hFFFF, 32'h0000_00F0},
        {1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 5'd5,  16'h0030, 32'h0000_0010},
        {1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 5'd0,  16'h0001, 32'h0000_0080},
        {1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 5'd31, 16'h8000, 32'h0000_0060},
        {1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 5'd9,  16'hFFFF, 32'h0000_0080}
    };

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int lat, n;
        logic [31:0] st;
        init_state();
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(!busy && !done && !mem_req && !rf_we, "R11 reset outputs idle",
            {busy, done, mem_req, rf_we}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !mem_req, "R11 idle after reset release", {busy, done, mem_req}, 0);

        // vector table: R2 R3 R4 R5 R6 R7 R8 R9
        for (int v = 0; v < NVEC; v++) begin
            logic [57:0] e;
            e = VECS[v];
            init_state();
            model(e[57], e[56], e[55], e[54], e[53], e[52:48], e[47:32], e[31:0], n, st);
            run_op(mk(3'b100, e[57], e[56], e[55], e[54], e[52:48], 2'b00, e[53], e[47:32]),
                   e[31:0], v[0], 1'b0, lat);
            chk(!got_ill, "R1 legal word not flagged", got_ill, 0);
            chk(beat_cnt == n, "R3 beat count", beat_cnt, n);
            chk(first_addr == st, "R4 first address", first_addr, st);
            if (v[0] && n > 0) chk(stall_cyc > 0, "R7 stalls were applied", stall_cyc, 1);
            compare($sformatf("R2/R5/R6/R8/R9 vector %0d", v));
        end

        // R1: wrong class bits
        init_state();
        run_op(mk(3'b011, 1'b0, 1'b1, 1'b1, 1'b1, 5'd1, 2'b00, 1'b0, 16'h00FF), 32'h40, 1'b0, 1'b0, lat);
        chk(got_ill && lat == 1, "R1 wrong class flagged", {got_ill, lat[7:0]}, {1'b1, 8'd1});
        chk(beat_cnt == 0, "R1 no beat on wrong class", beat_cnt, 0);
        compare("R1 wrong class untouched");

        // R1: nonzero pad bits
        init_state();
        run_op(mk(3'b100, 1'b0, 1'b1, 1'b1, 1'b0, 5'd1, 2'b10, 1'b0, 16'h00FF), 32'h40, 1'b0, 1'b0, lat);
        chk(got_ill && lat == 1, "R1 pad bit flagged", {got_ill, lat[7:0]}, {1'b1, 8'd1});
        compare("R1 pad bit untouched");

        // R10: empty mask, no writeback
        init_state();
        run_op(mk(3'b100, 1'b1, 1'b1, 1'b0, 1'b1, 5'd4, 2'b00, 1'b0, 16'h0000), 32'h40, 1'b0, 1'b0, lat);
        chk(lat == 1 && !got_ill, "R10 empty mask latency", lat, 1);
        chk(beat_cnt == 0, "R10 empty mask no beat", beat_cnt, 0);
        compare("R10 empty mask W=0");

        // R10: empty mask with writeback (N=0 -> base unchanged)
        init_state();
        exp_rf[7] = 32'h0000_0044;
        run_op(mk(3'b100, 1'b0, 1'b0, 1'b1, 1'b0, 5'd7, 2'b00, 1'b0, 16'h0000), 32'h44, 1'b0, 1'b0, lat);
        chk(lat == 2, "R10 empty mask writeback latency", lat, 2);
        chk(beat_cnt == 0, "R10 empty mask writeback no beat", beat_cnt, 0);
        compare("R10 empty mask W=1");

        // R11: start while busy is ignored
        init_state();
        model(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 5'd2, 16'h0F0F, 32'h0000_0080, n, st);
        run_op(mk(3'b100, 1'b0, 1'b1, 1'b0, 1'b1, 5'd2, 2'b00, 1'b1, 16'h0F0F), 32'h80, 1'b1, 1'b1, lat);
        chk(beat_cnt == n, "R11 busy start ignored beats", beat_cnt, n);
        compare("R11 busy start ignored");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule